// File: doc/BRIEF.md
# ADC Conversion Sequencer with Sample FIFO

This block runs an analog-to-digital converter through a programmable list of conversion steps. Software loads a table in which each step names an input channel (a 5-bit mux select) and a sample window counted in divided clocks. Two steps are packed into each 32-bit table word. Once the block is enabled and started, it walks the table from the step pointer onward. For each step it waits out the window, asks the external converter for a conversion and stores the 12-bit result in a receive FIFO. Results from lower resolutions are left-aligned, with their low bits forced to zero.

A step whose window is too short for the selected resolution is not converted: the block raises a sticky sequence-error flag and stops. A sticky data-available flag rises when the FIFO holds more results than the programmed threshold. Each flag drives an interrupt output through its own mask. Software takes results by writing a pop request, which moves the oldest FIFO entry into the sample register. A flush request empties the FIFO. Popping an empty FIFO sets a sticky underflow indication.

A control word and a settings word are written whole. Fields that request an action (table reset, pointer reset, flag clears, flush, pop) act once per write and are not stored.

Top module: `adc_seq_top`

## Requirements
- R1: Each table write appends one word. Entry 2k sits in word k at mux [4:0] and window [15:5], and entry 2k+1 at mux [20:16] and window [31:21]. Entries are converted in ascending order, and `conv_mux_o` carries the entry's mux value while `conv_req_o` is high.
- R2: Settings bits [19:16] hold the index of the last entry (zero-based). With settings bit 13 = 0 the sequencer stops after the last entry and clears start. With bit 13 = 1 it wraps to entry 0 and keeps running.
- R3: Settings bits [4:0] select the resolution: code 0 = 6, 1 = 8, 2 = 10, 3 = 12 bits, and any other code = 12 bits. Stored results keep the top N bits of the converter data and have the lower 12-N bits cleared.
- R4: An entry whose window is below resolution+2 is not converted. Instead it sets the sequence-error flag and clears start. A window equal to resolution+2 converts.
- R5: The window counts ticks of a divider set by `div_ratio_i`, where a ratio of 0 acts as 1. The request rises about window×ratio cycles after the run begins.
- R6: Each result is pushed into the FIFO. A pop (settings bit 15) moves the oldest entry to `sample_o`. Results that arrive while the FIFO is full are discarded.
- R7: A pop while the FIFO is empty leaves `sample_o` unchanged and sets `underflow_o`. `underflow_o` stays set until a clear-all.
- R8: A flush (settings bit 14) empties the FIFO and does not change `sample_o`. A flush takes priority over a pop in the same write.
- R9: The data-available flag sets while the FIFO level exceeds settings bits [26:24]. It stays set until control bit 4 clears it. `irq_data_o` is the flag gated by mask control bit 7.
- R10: Control bit 5 clears the sequence-error flag, and control bit 6 clears both flags and underflow. `irq_err_o` is the error flag gated by mask control bit 8, and a masked flag still persists.
- R11: Control bit 2 empties the table, so a run over the empty table raises a sequence error. Control bit 3 returns the step pointer to entry 0. Without it, a stopped run resumes at the entry where it stopped.
- R12: Conversions run only while control bit 0 (enable) and bit 1 (start) are both set. Clearing either stops further conversions.
- R13: Settings bit 6 (capture edge), bit 7 (output mode) and bits [12:8] (serial delay) appear on `cfg_edge_o`, `cfg_par_o` and `cfg_sdly_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word |
| set_we_i | input | 1 | Settings word write strobe |
| set_wdata_i | input | 32 | Settings word |
| tbl_we_i | input | 1 | Table append strobe |
| tbl_wdata_i | input | 32 | Table word (two entries) |
| div_ratio_i | input | DIV_W | Window clock divider ratio |
| sample_o | output | 12 | Sample register |
| underflow_o | output | 1 | Sticky pop-on-empty indication |
| irq_data_o | output | 1 | Data-available interrupt |
| irq_err_o | output | 1 | Sequence-error interrupt |
| conv_req_o | output | 1 | Conversion request to converter |
| conv_mux_o | output | 5 | Channel select for the request |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | 12 | Converter result |
| cfg_edge_o | output | 1 | Capture edge setting |
| cfg_par_o | output | 1 | Output mode setting |
| cfg_sdly_o | output | 5 | Serial delay setting |

## Verification
Some properties are checked on every cycle:
- the channel select holds steady while a request waits for its result;
- a request exists only after a cycle with enable and start both set;
- the FIFO level never passes its depth;
- the data-available and underflow flags persist until their clears;
- a sequence error is never followed by a request.

Other behaviours show only through the bench's directed scenarios:
- conversion order, stopping and wrap-around;
- left alignment per resolution;
- the window boundary at resolution+2;
- divider timing;
- discarding when the FIFO is full, flush, and pointer retention or reset.

The converter model in the bench returns a value derived from the channel select, so each result can be traced back to its table entry.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int MUX_W = 5;
  localparam int WIN_W = 11;
  localparam int SMP_W = 12;

  // control word bits
  localparam int C_EN      = 0;
  localparam int C_START   = 1;
  localparam int C_TBL_RST = 2;
  localparam int C_PTR_RST = 3;
  localparam int C_CLR_DA  = 4;
  localparam int C_CLR_ERR = 5;
  localparam int C_CLR_ALL = 6;
  localparam int C_MSK_DA  = 7;
  localparam int C_MSK_ERR = 8;

  // settings word bits
  localparam int S_RES   = 0;
  localparam int S_EDGE  = 6;
  localparam int S_PAR   = 7;
  localparam int S_SDLY  = 8;
  localparam int S_REP   = 13;
  localparam int S_FLUSH = 14;
  localparam int S_POP   = 15;
  localparam int S_LAST  = 16;
  localparam int S_THR   = 24;

  typedef struct packed {
    logic [WIN_W-1:0] win;
    logic [MUX_W-1:0] mux;
  } entry_t;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_CONV} seq_st_e;

  function automatic logic [4:0] res_bits(input logic [4:0] code);
    case (code)
      5'd0:    res_bits = 5'd6;
      5'd1:    res_bits = 5'd8;
      5'd2:    res_bits = 5'd10;
      default: res_bits = 5'd12;
    endcase
  endfunction

  function automatic logic [SMP_W-1:0] align_mask(input logic [4:0] code);
    case (code)
      5'd0:    align_mask = 12'hFC0;
      5'd1:    align_mask = 12'hFF0;
      5'd2:    align_mask = 12'hFFC;
      default: align_mask = 12'hFFF;
    endcase
  endfunction
endpackage

// File: rtl/adc_seq_table.sv
module adc_seq_table
  import adc_seq_pkg::*;
#(
  parameter int TBL_WORDS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                we_i,
  input  logic [31:0]         wdata_i,
  input  logic [$clog2(2*TBL_WORDS)-1:0] idx_i,
  output entry_t              ent_o,
  output logic                valid_o
);
  localparam int EIW = $clog2(2*TBL_WORDS);
  localparam int WAW = EIW - 1;
  localparam int WCW = WAW + 1;

  logic [31:0]    word_q [TBL_WORDS];
  logic [WCW-1:0] wcnt_q;
  logic           wr_en;
  logic [WAW-1:0] rd_word;

  assign wr_en = we_i && !clr_i && (wcnt_q < WCW'(TBL_WORDS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wcnt_q <= '0;
    else if (clr_i) wcnt_q <= '0;
    else if (wr_en) wcnt_q <= wcnt_q + WCW'(1);
  end

  for (genvar w = 0; w < TBL_WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            word_q[w] <= '0;
      else if (wr_en && wcnt_q == WCW'(w))    word_q[w] <= wdata_i;
    end
  end

  assign rd_word = idx_i[EIW-1:1];
  assign valid_o = {1'b0, rd_word} < wcnt_q;
  assign ent_o   = idx_i[0] ? entry_t'(word_q[rd_word][31:16])
                            : entry_t'(word_q[rd_word][15:0]);
endmodule

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       push_i,
  input  logic [SMP_W-1:0]           push_data_i,
  input  logic                       pop_i,
  output logic [SMP_W-1:0]           head_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [SMP_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [LW-1:0]    level_q;
  logic             full, do_push, do_pop;

  assign empty_o = (level_q == '0);
  assign full    = (level_q == LW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q <= '0; rd_q <= '0; level_q <= '0;
    end else if (flush_i) begin
      wr_q <= '0; rd_q <= '0; level_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + AW'(1);
      if (do_pop)  rd_q <= rd_q + AW'(1);
      level_q <= level_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= push_data_i;
  end

  assign head_o  = mem_q[rd_q];
  assign level_o = level_q;
endmodule

// File: rtl/adc_seq_engine.sv
module adc_seq_engine
  import adc_seq_pkg::*;
#(
  parameter int TBL_WORDS = 8,
  parameter int DIV_W     = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           run_i,
  input  logic                           ptr_rst_i,
  input  logic [4:0]                     res_code_i,
  input  logic [$clog2(2*TBL_WORDS)-1:0] last_idx_i,
  input  logic                           repeat_i,
  input  logic [DIV_W-1:0]               div_i,
  output logic [$clog2(2*TBL_WORDS)-1:0] idx_o,
  input  entry_t                         ent_i,
  input  logic                           ent_valid_i,
  output logic                           conv_req_o,
  output logic [MUX_W-1:0]               conv_mux_o,
  input  logic                           conv_done_i,
  input  logic [SMP_W-1:0]               conv_data_i,
  output logic                           push_o,
  output logic [SMP_W-1:0]               push_data_o,
  output logic                           seq_err_o,
  output logic                           pass_done_o
);
  localparam int EIW = $clog2(2*TBL_WORDS);

  seq_st_e          st_q, st_d;
  logic [EIW-1:0]   ptr_q;
  logic [MUX_W-1:0] mux_q;
  logic [WIN_W-1:0] win_q, win_cnt_q, need;
  logic [DIV_W-1:0] div_cnt_q, div_last;
  logic             tick, load, adv, wrap;

  assign need     = WIN_W'(res_bits(res_code_i)) + WIN_W'(2);
  assign div_last = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  assign tick     = (div_cnt_q == div_last);
  assign wrap     = (ptr_q == last_idx_i);

  always_comb begin
    st_d        = st_q;
    load        = 1'b0;
    adv         = 1'b0;
    push_o      = 1'b0;
    seq_err_o   = 1'b0;
    pass_done_o = 1'b0;
    case (st_q)
      ST_IDLE: if (run_i) begin
        if (!ent_valid_i || ent_i.win < need) seq_err_o = 1'b1;
        else begin st_d = ST_WAIT; load = 1'b1; end
      end
      ST_WAIT: begin
        if (!run_i) st_d = ST_IDLE;
        else if (tick && win_cnt_q == win_q - WIN_W'(1)) st_d = ST_CONV;
      end
      ST_CONV: begin
        if (!run_i) st_d = ST_IDLE;
        else if (conv_done_i) begin
          push_o      = 1'b1;
          adv         = 1'b1;
          pass_done_o = wrap && !repeat_i;
          st_d        = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      ptr_q     <= '0;
      mux_q     <= '0;
      win_q     <= '0;
      win_cnt_q <= '0;
      div_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (load) begin
        mux_q     <= ent_i.mux;
        win_q     <= ent_i.win;
        win_cnt_q <= '0;
        div_cnt_q <= '0;
      end else if (st_q == ST_WAIT) begin
        div_cnt_q <= tick ? '0 : div_cnt_q + DIV_W'(1);
        if (tick) win_cnt_q <= win_cnt_q + WIN_W'(1);
      end
      if (ptr_rst_i)  ptr_q <= '0;
      else if (adv)   ptr_q <= wrap ? '0 : ptr_q + EIW'(1);
    end
  end

  assign idx_o       = ptr_q;
  assign conv_req_o  = (st_q == ST_CONV);
  assign conv_mux_o  = mux_q;
  assign push_data_o = conv_data_i & align_mask(res_code_i);
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int TBL_WORDS  = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [31:0]      ctrl_wdata_i,
  input  logic             set_we_i,
  input  logic [31:0]      set_wdata_i,
  input  logic             tbl_we_i,
  input  logic [31:0]      tbl_wdata_i,
  input  logic [DIV_W-1:0] div_ratio_i,
  output logic [11:0]      sample_o,
  output logic             underflow_o,
  output logic             irq_data_o,
  output logic             irq_err_o,
  output logic             conv_req_o,
  output logic [4:0]       conv_mux_o,
  input  logic             conv_done_i,
  input  logic [11:0]      conv_data_i,
  output logic             cfg_edge_o,
  output logic             cfg_par_o,
  output logic [4:0]       cfg_sdly_o
);
  localparam int EIW = $clog2(2*TBL_WORDS);
  localparam int FLW = $clog2(FIFO_DEPTH);
  localparam int LW  = $clog2(FIFO_DEPTH+1);

  logic [31:0]      set_q;
  logic             en_q, start_q, msk_da_q, msk_err_q;
  logic             da_q, err_q, unf_q;
  logic [SMP_W-1:0] sample_q;

  logic tbl_clr, ptr_rst, clr_all, da_clr, err_clr, flush, pop_req;
  logic run, seq_err, pass_done, push, fifo_empty;
  logic [SMP_W-1:0] push_data, head;
  logic [LW-1:0]    fifo_level;
  logic [EIW-1:0]   idx;
  entry_t           ent;
  logic             ent_valid;
  logic             unused_bits;

  assign unused_bits = ^{set_q, ctrl_wdata_i};

  assign tbl_clr = ctrl_we_i && ctrl_wdata_i[C_TBL_RST];
  assign ptr_rst = ctrl_we_i && ctrl_wdata_i[C_PTR_RST];
  assign clr_all = ctrl_we_i && ctrl_wdata_i[C_CLR_ALL];
  assign da_clr  = ctrl_we_i && (ctrl_wdata_i[C_CLR_DA] || ctrl_wdata_i[C_CLR_ALL]);
  assign err_clr = ctrl_we_i && (ctrl_wdata_i[C_CLR_ERR] || ctrl_wdata_i[C_CLR_ALL]);
  assign flush   = set_we_i && set_wdata_i[S_FLUSH];
  assign pop_req = set_we_i && set_wdata_i[S_POP] && !set_wdata_i[S_FLUSH];
  assign run     = en_q && start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      set_q <= '0;
    end else if (set_we_i) begin
      set_q <= set_wdata_i;
      set_q[S_FLUSH] <= 1'b0;
      set_q[S_POP]   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; start_q <= 1'b0; msk_da_q <= 1'b0; msk_err_q <= 1'b0;
    end else if (ctrl_we_i) begin
      en_q      <= ctrl_wdata_i[C_EN];
      start_q   <= ctrl_wdata_i[C_START];
      msk_da_q  <= ctrl_wdata_i[C_MSK_DA];
      msk_err_q <= ctrl_wdata_i[C_MSK_ERR];
    end else if (seq_err || pass_done) begin
      start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      da_q <= 1'b0; err_q <= 1'b0; unf_q <= 1'b0; sample_q <= '0;
    end else begin
      da_q  <= (fifo_level > LW'(set_q[S_THR +: FLW])) || (da_q && !da_clr);
      err_q <= seq_err || (err_q && !err_clr);
      unf_q <= (pop_req && fifo_empty) || (unf_q && !clr_all);
      if (pop_req && !fifo_empty) sample_q <= head;
    end
  end

  adc_seq_table #(.TBL_WORDS(TBL_WORDS)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tbl_clr),
    .we_i    (tbl_we_i),
    .wdata_i (tbl_wdata_i),
    .idx_i   (idx),
    .ent_o   (ent),
    .valid_o (ent_valid)
  );

  adc_seq_engine #(.TBL_WORDS(TBL_WORDS), .DIV_W(DIV_W)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run),
    .ptr_rst_i   (ptr_rst),
    .res_code_i  (set_q[S_RES +: 5]),
    .last_idx_i  (set_q[S_LAST +: EIW]),
    .repeat_i    (set_q[S_REP]),
    .div_i       (div_ratio_i),
    .idx_o       (idx),
    .ent_i       (ent),
    .ent_valid_i (ent_valid),
    .conv_req_o  (conv_req_o),
    .conv_mux_o  (conv_mux_o),
    .conv_done_i (conv_done_i),
    .conv_data_i (conv_data_i),
    .push_o      (push),
    .push_data_o (push_data),
    .seq_err_o   (seq_err),
    .pass_done_o (pass_done)
  );

  adc_seq_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop_req),
    .head_o      (head),
    .empty_o     (fifo_empty),
    .level_o     (fifo_level)
  );

  assign sample_o    = sample_q;
  assign underflow_o = unf_q;
  assign irq_data_o  = da_q && !msk_da_q;
  assign irq_err_o   = err_q && !msk_err_q;
  assign cfg_edge_o  = set_q[S_EDGE];
  assign cfg_par_o   = set_q[S_PAR];
  assign cfg_sdly_o  = set_q[S_SDLY +: 5];
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int FIFO_DEPTH = 8
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           conv_req_o,
  input logic                           conv_done_i,
  input logic [4:0]                     conv_mux_o,
  input logic                           en_q,
  input logic                           start_q,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  input logic                           da_q,
  input logic                           da_clr,
  input logic                           unf_q,
  input logic                           clr_all,
  input logic                           seq_err
);
  localparam int LW = $clog2(FIFO_DEPTH+1);

  assert_mux_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_req_o && !conv_done_i) |=> (!conv_req_o || $stable(conv_mux_o)));

  assert_err_no_conv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err |=> !conv_req_o);

  assert_level_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_level <= LW'(FIFO_DEPTH));

  assert_unf_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unf_q && !clr_all) |=> unf_q);

  assert_da_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_q && !da_clr) |=> da_q);

  assert_req_needs_run_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_req_o) |-> $past(en_q && start_q));
endmodule

bind adc_seq_top adc_seq_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .conv_req_o  (conv_req_o),
  .conv_done_i (conv_done_i),
  .conv_mux_o  (conv_mux_o),
  .en_q        (en_q),
  .start_q     (start_q),
  .fifo_level  (fifo_level),
  .da_q        (da_q),
  .da_clr      (da_clr),
  .unf_q       (unf_q),
  .clr_all     (clr_all),
  .seq_err     (seq_err)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0, set_we = 1'b0, tbl_we = 1'b0;
  logic [31:0] ctrl_wd = '0, set_wd = '0, tbl_wd = '0;
  logic [7:0]  div_ratio = 8'd1;
  logic [11:0] sample;
  logic        underflow, irq_data, irq_err, conv_req, conv_done;
  logic [4:0]  conv_mux, cfg_sdly;
  logic [11:0] conv_data;
  logic        cfg_edge, cfg_par;

  int n_tests = 0, n_fail = 0;
  int cyc = 0, req_cyc = 0, log_n = 0;
  logic       req_prev = 1'b0;
  logic [4:0] log_mux [64];
  int         cm_cnt = 0;
  logic [31:0] set_sh = '0;

  always #4 clk = ~clk;

  adc_seq_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd),
    .set_we_i(set_we), .set_wdata_i(set_wd),
    .tbl_we_i(tbl_we), .tbl_wdata_i(tbl_wd),
    .div_ratio_i(div_ratio),
    .sample_o(sample), .underflow_o(underflow),
    .irq_data_o(irq_data), .irq_err_o(irq_err),
    .conv_req_o(conv_req), .conv_mux_o(conv_mux),
    .conv_done_i(conv_done), .conv_data_i(conv_data),
    .cfg_edge_o(cfg_edge), .cfg_par_o(cfg_par), .cfg_sdly_o(cfg_sdly)
  );

  function automatic logic [11:0] cdata(input logic [4:0] m);
    return 12'hA5F ^ {7'd0, m};
  endfunction

  // converter model: result three cycles into a request
  always @(posedge clk) begin
    if (!rst_n) begin
      conv_done <= 1'b0; conv_data <= '0; cm_cnt <= 0;
    end else begin
      conv_done <= 1'b0;
      if (conv_req && !conv_done) begin
        if (cm_cnt == 2) begin
          conv_done <= 1'b1; conv_data <= cdata(conv_mux); cm_cnt <= 0;
        end else cm_cnt <= cm_cnt + 1;
      end else cm_cnt <= 0;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    req_prev <= conv_req;
    if (conv_req && !req_prev) req_cyc <= cyc;
    if (rst_n && conv_req && conv_done) begin
      log_mux[log_n % 64] <= conv_mux;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [31:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wd = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_set(input logic [31:0] v);
    @(negedge clk); set_we = 1'b1; set_wd = v;
    @(negedge clk); set_we = 1'b0;
  endtask

  task automatic wr_tbl(input logic [4:0] m0, input logic [10:0] w0,
                        input logic [4:0] m1, input logic [10:0] w1);
    @(negedge clk); tbl_we = 1'b1; tbl_wd = {w1, m1, w0, m0};
    @(negedge clk); tbl_we = 1'b0;
  endtask

  function automatic logic [31:0] mkset(input int res, input int rep, input int last, input int thr);
    return (32'(res) & 32'h1F) | (32'(rep) << 13) | (32'(last) << 16) | (32'(thr) << 24);
  endfunction

  task automatic cfg_set(input logic [31:0] v);
    set_sh = v; wr_set(v);
  endtask

  task automatic pop();
    wr_set(set_sh | 32'h8000);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_convs(input int base, input int n);
    for (int i = 0; i < 3000 && (log_n - base) < n; i++) @(negedge clk);
  endtask

  // stop, flush FIFO, empty table, clear flags
  task automatic prep();
    wr_ctrl(32'h0);
    wr_set(set_sh | 32'h4000);
    wr_ctrl(32'h44);
  endtask

  task automatic t_reset();
    chk("R6 reset sample", sample, 0);
    chk("R7 reset underflow", underflow, 0);
    chk("R9 reset irq_data", irq_data, 0);
    chk("R10 reset irq_err", irq_err, 0);
    chk("R12 reset conv_req", conv_req, 0);
  endtask

  task automatic t_single_pass();
    int base;
    prep();
    div_ratio = 8'd1;
    wr_tbl(5'd3, 11'd20, 5'd7, 11'd20);
    wr_tbl(5'd12, 11'd20, 5'd0, 11'd0);
    cfg_set(mkset(3, 0, 2, 2));
    base = log_n;
    wr_ctrl(32'h3);
    wait_convs(base, 3);
    idle(200);
    chk("R2 single pass stops after last", log_n - base, 3);
    chk("R1 order entry0", log_mux[base % 64], 3);
    chk("R1 order entry1", log_mux[(base+1) % 64], 7);
    chk("R1 order entry2", log_mux[(base+2) % 64], 12);
    chk("R9 level 3 over thr 2", irq_data, 1);
    pop(); chk("R6 pop first", sample, cdata(5'd3));
    pop(); chk("R6 pop second", sample, cdata(5'd7));
    pop(); chk("R6 pop third", sample, cdata(5'd12));
    chk("R9 flag sticky after drain", irq_data, 1);
    wr_ctrl(32'h10);
    idle(1);
    chk("R9 clear data flag", irq_data, 0);
    pop();
    chk("R7 empty pop keeps sample", sample, cdata(5'd12));
    chk("R7 underflow set", underflow, 1);
    idle(20);
    chk("R7 underflow sticky", underflow, 1);
    wr_ctrl(32'h40);
    idle(1);
    chk("R10 clear all underflow", underflow, 0);
  endtask

  task automatic t_resolution();
    logic [11:0] exp [3];
    exp[0] = cdata(5'd9) & 12'hFC0;
    exp[1] = cdata(5'd9) & 12'hFF0;
    exp[2] = cdata(5'd9) & 12'hFFC;
    prep();
    wr_tbl(5'd9, 11'd20, 5'd0, 11'd0);
    for (int r = 0; r < 3; r++) begin
      int base;
      cfg_set(mkset(r, 0, 0, 7));
      base = log_n;
      wr_ctrl(32'h3);
      wait_convs(base, 1);
      idle(5);
      pop();
      chk($sformatf("R3 align code %0d", r), sample, exp[r]);
    end
    cfg_set(mkset(7, 0, 0, 7));
    wr_ctrl(32'h3);
    idle(60);
    pop();
    chk("R3 code 7 acts as 12 bits", sample, cdata(5'd9));
  endtask

  task automatic t_window();
    int base;
    prep();
    wr_tbl(5'd1, 11'd13, 5'd0, 11'd0);
    cfg_set(mkset(3, 0, 0, 7));
    base = log_n;
    wr_ctrl(32'h3);
    idle(60);
    chk("R4 short window raises error", irq_err, 1);
    chk("R4 short window no conversion", log_n - base, 0);
    wr_ctrl(32'h20);
    idle(1);
    chk("R10 clear error flag", irq_err, 0);
    wr_ctrl(32'h4);
    wr_tbl(5'd1, 11'd14, 5'd0, 11'd0);
    base = log_n;
    wr_ctrl(32'h3);
    idle(60);
    chk("R4 window equal to bound converts", log_n - base, 1);
    chk("R4 no error on bound", irq_err, 0);
    wr_ctrl(32'h4);
    wr_tbl(5'd1, 11'd13, 5'd0, 11'd0);
    wr_ctrl(32'h103);
    idle(40);
    chk("R10 error masked", irq_err, 0);
    wr_ctrl(32'h0);
    idle(1);
    chk("R10 masked flag persists", irq_err, 1);
    wr_ctrl(32'h40);
    idle(1);
    chk("R10 clear all error", irq_err, 0);
  endtask

  task automatic t_divider();
    int c0;
    prep();
    wr_tbl(5'd2, 11'd10, 5'd0, 11'd0);
    cfg_set(mkset(0, 0, 0, 7));
    for (int k = 0; k < 3; k++) begin
      int d, lo;
      d = (k == 0) ? 4 : (k == 1) ? 1 : 0;
      lo = (d == 0) ? 10 : 10 * d;
      div_ratio = 8'(d);
      wr_ctrl(32'h3);
      c0 = cyc;
      idle(80);
      n_tests++;
      if (req_cyc - c0 < lo || req_cyc - c0 > lo + 6) begin
        n_fail++;
        $display("FAIL R5 ratio %0d actual=%0d expected=%0d..%0d", d, req_cyc - c0, lo, lo + 6);
      end
    end
    div_ratio = 8'd1;
  endtask

  task automatic t_repeat_full();
    int base, n;
    prep();
    wr_tbl(5'd4, 11'd14, 5'd5, 11'd14);
    cfg_set(mkset(3, 1, 1, 7));
    base = log_n;
    wr_ctrl(32'h3);
    wait_convs(base, 10);
    wr_ctrl(32'h0);
    idle(40);
    n = log_n;
    idle(100);
    chk("R12 stop after start cleared", log_n, n);
    for (int i = 0; i < 6; i++)
      chk("R2 repeat alternates", log_mux[(base+i) % 64], (i % 2 == 0) ? 4 : 5);
    chk("R9 full FIFO over thr 7", irq_data, 1);
    for (int i = 0; i < 8; i++) begin
      pop();
      chk("R6 fifo order", sample, cdata(log_mux[(base+i) % 64]));
    end
    pop();
    chk("R6 results beyond depth dropped", underflow, 1);
    wr_ctrl(32'h40);
    n = log_n;
    wr_ctrl(32'h2);
    idle(100);
    chk("R12 start without enable idle", log_n, n);
    wr_ctrl(32'h1);
    idle(100);
    chk("R12 enable without start idle", log_n, n);
  endtask

  task automatic t_flush();
    int base;
    logic [11:0] held;
    prep();
    wr_tbl(5'd6, 11'd14, 5'd8, 11'd14);
    cfg_set(mkset(3, 0, 1, 1));
    base = log_n;
    wr_ctrl(32'h3);
    wait_convs(base, 2);
    idle(5);
    chk("R9 level 2 over thr 1", irq_data, 1);
    wr_ctrl(32'h80);
    idle(1);
    chk("R9 data irq masked", irq_data, 0);
    wr_ctrl(32'h0);
    idle(1);
    chk("R9 unmasked flag persists", irq_data, 1);
    pop();
    chk("R6 pop after run", sample, cdata(5'd6));
    held = sample;
    wr_ctrl(32'h10);
    idle(1);
    chk("R9 level 1 not over thr 1", irq_data, 0);
    wr_set(set_sh | 32'h4000);
    chk("R8 flush keeps sample", sample, held);
    pop();
    chk("R8 flush empties fifo", underflow, 1);
    chk("R8 sample unchanged after flush", sample, held);
    wr_ctrl(32'h40);
  endtask

  task automatic t_table_ptr();
    int base;
    prep();
    cfg_set(mkset(3, 1, 1, 7));
    wr_ctrl(32'h3);
    idle(10);
    chk("R11 empty table raises error", irq_err, 1);
    wr_ctrl(32'h40);
    wr_tbl(5'd6, 11'd14, 5'd8, 11'd14);
    base = log_n;
    wr_ctrl(32'h3);
    wait_convs(base, 3);
    wr_ctrl(32'h0);
    idle(30);
    base = log_n;
    wr_ctrl(32'h3);
    wait_convs(base, 2);
    wr_ctrl(32'h0);
    idle(30);
    chk("R11 resume at stopped entry", log_mux[base % 64], 8);
    base = log_n;
    wr_ctrl(32'hB);
    wait_convs(base, 1);
    wr_ctrl(32'h0);
    idle(30);
    chk("R11 pointer reset to entry 0", log_mux[base % 64], 6);
  endtask

  task automatic t_cfg();
    cfg_set(32'h0000_15C0);
    chk("R13 capture edge", cfg_edge, 1);
    chk("R13 output mode", cfg_par, 1);
    chk("R13 serial delay", cfg_sdly, 5'h15);
    cfg_set(32'h0);
    chk("R13 edge cleared", cfg_edge, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_pass();
    t_resolution();
    t_window();
    t_divider();
    t_repeat_full();
    t_flush();
    t_table_ptr();
    t_cfg();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule